// File: doc/BRIEF.md
# Periodic Impedance Calibration Controller

This controller holds a binary-weighted drive-strength code for an output driver and keeps it matched to an external reference resistor. A free-running interval counter fires an evaluation every `INTERVAL` clock cycles, forever. At each evaluation the controller reads a two-bit comparator result, which stands in for the analog sensing of the driver against the reference. It then moves the code by at most one LSB toward balance. The code saturates at both ends and never wraps.

Each code bit enables one binary-weighted driver leg, so the code is proportional to drive conductance. The driver is meant to present one fifth of the reference resistance. Input termination is meant to present 0.6 times that resistance, which is three times the driver impedance. The termination code is therefore one third of the drive code, rounded to nearest. It is refreshed at the same edge as the drive code. A termination-enable input gates the termination code to zero without stopping drive calibration.

A one-cycle `eval_done_o` pulse marks each evaluation, so a consumer can pair every code movement with an evaluation.

Top module: `zcal_ctrl`

## Requirements
- R1: `eval_done_o` is high for exactly one cycle after every INTERVAL-th rising clock edge counted from reset release. The drive and termination codes change only at those edges.
- R2: During reset, `drv_code_o` is mid-scale (only the MSB set) and `eval_done_o` is 0. The internal termination value equals (mid-scale+1)/3.
- R3: `cmp_i` is decoded at an evaluation as follows. 2'b10 means drive is too weak and increments the code. 2'b01 means drive is too strong and decrements it. 2'b00 and 2'b11 hold the code. An evaluation never moves the code by more than one.
- R4: `cmp_i` is ignored in every cycle that is not an evaluation.
- R5: An increment request with the code at all-ones leaves it at all-ones.
- R6: A decrement request with the code at zero leaves it at zero.
- R7: With termination enabled, `term_code_o` equals floor((drv_code_o+1)/3). It is updated at the same edge as the drive code.
- R8: While `odt_en_i` is low, `term_code_o` is zero in that same cycle, and drive calibration keeps stepping. Raising `odt_en_i` restores the derived value without waiting for an evaluation.
- R9: `eval_done_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 | Comparator result: 2'b10 too weak, 2'b01 too strong, others balanced |
| odt_en_i | input | 1 | Input termination enable, active high |
| drv_code_o | output | CODE_W | Binary-weighted driver leg enables |
| term_code_o | output | CODE_W | Termination leg enables, zero when disabled |
| eval_done_o | output | 1 | One-cycle pulse after each evaluation |

## Verification
The hardest case to reach from the ports is a comparator that asks for a change in every cycle except the evaluation cycle. A design that samples the comparator at the wrong time would then drift where a correct one stays put. The bench keeps its own copy of the interval count. It drives an increment request on all non-evaluation cycles and a hold on the predicted evaluation cycles. The drive code must not move during this phase. The saturation ends are reached by forcing the comparator in one direction for more evaluations than the code span. The termination enable is dropped while the model target moves, so the bench can see that stepping continues behind a zeroed termination code.

// File: rtl/zcal_pkg.sv
`timescale 1ns/1ps
package zcal_pkg;
  typedef enum logic [1:0] {
    CMP_HOLD = 2'b00,
    CMP_DEC  = 2'b01,
    CMP_INC  = 2'b10,
    CMP_BOTH = 2'b11
  } cmp_e;
endpackage

// File: rtl/zcal_interval.sv
`timescale 1ns/1ps
module zcal_interval #(
  parameter int INTERVAL = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic evt_o
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign evt_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= RELOAD;
    else if (evt_o) cnt_q <= RELOAD;
    else            cnt_q <= cnt_q - 1'b1;
  end

  // evaluation strobes are isolated when the interval exceeds one cycle
  p_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/zcal_stepper.sv
`timescale 1ns/1ps
module zcal_stepper
  import zcal_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  cmp_e              cmp_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (evt_i) begin
      unique case (cmp_i)
        CMP_INC: if (code_q != CODE_MAX) code_d = code_q + 1'b1;
        CMP_DEC: if (code_q != CODE_MIN) code_d = code_q - 1'b1;
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_MID;
    else         code_q <= code_d;
  end

  assign code_o     = code_q;
  assign code_nxt_o = code_d;

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == $past(code_q)) ||
    ({1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1) ||
    ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)}));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(code_q));

  p_sat_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && cmp_i == CMP_INC && code_q == CODE_MAX) |=> code_q == CODE_MAX);

  p_sat_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && cmp_i == CMP_DEC && code_q == CODE_MIN) |=> code_q == CODE_MIN);
endmodule

// File: rtl/zcal_term.sv
`timescale 1ns/1ps
module zcal_term #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [CODE_W-1:0] code_nxt_i,
  input  logic              en_i,
  output logic [CODE_W-1:0] term_o
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] MID_SUM = (SUM_W'(1) << (CODE_W - 1)) + SUM_W'(1);
  localparam logic [SUM_W-1:0] RST_Q   = MID_SUM / SUM_W'(3);

  logic [SUM_W-1:0]  sum, quot;
  logic [CODE_W-1:0] term_q;

  // termination impedance is 3x driver impedance: one third of the legs, rounded
  always_comb begin
    sum  = {1'b0, code_nxt_i} + SUM_W'(1);
    quot = sum / SUM_W'(3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    term_q <= RST_Q[CODE_W-1:0];
    else if (evt_i) term_q <= quot[CODE_W-1:0];
  end

  assign term_o = en_i ? term_q : '0;

  p_term_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(term_q));
endmodule

// File: rtl/zcal_ctrl.sv
`timescale 1ns/1ps
module zcal_ctrl
  import zcal_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmp_i,
  input  logic              odt_en_i,
  output logic [CODE_W-1:0] drv_code_o,
  output logic [CODE_W-1:0] term_code_o,
  output logic              eval_done_o
);
  logic              evt;
  logic [CODE_W-1:0] code_nxt;
  logic              done_q;
  cmp_e              cmp;

  assign cmp = cmp_e'(cmp_i);

  zcal_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_o  (evt)
  );

  zcal_stepper #(.CODE_W(CODE_W)) u_stepper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .cmp_i      (cmp),
    .code_o     (drv_code_o),
    .code_nxt_o (code_nxt)
  );

  zcal_term #(.CODE_W(CODE_W)) u_term (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .code_nxt_i (code_nxt),
    .en_i       (odt_en_i),
    .term_o     (term_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= evt;
  end

  assign eval_done_o = done_q;

  p_change_on_eval_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_code_o != $past(drv_code_o)) |-> eval_done_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_done_o |=> !eval_done_o);
endmodule

// File: tb/sim_zcal_ctrl.sv
`timescale 1ns/1ps
module sim_zcal_ctrl;
  localparam int W  = 6;
  localparam int IV = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   cmp_i = 2'b00;
  logic         odt_en_i = 1'b0;
  logic [W-1:0] drv_code_o, term_code_o;
  logic         eval_done_o;

  int checks = 0, errors = 0;
  int mode = 0, target = 0, bcnt = 0;
  bit armed = 0, ended = 0;
  int exp_code = 32;
  int sb[$];

  zcal_ctrl #(.CODE_W(W), .INTERVAL(IV)) u0 (
    .clk_i, .rst_ni, .cmp_i, .odt_en_i, .drv_code_o, .term_code_o, .eval_done_o
  );

  always #2 clk_i = ~clk_i;

  function automatic int term_of(int c);
    return (c + 1) / 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_iv(int n);
    repeat (n * IV) @(posedge clk_i);
    #1;
  endtask

  // scoreboard monitor: predicts each edge, pushes evaluations, pops on done
  initial begin
    wait (armed);
    forever begin
      @(negedge clk_i);
      if (sb.size() > 0) begin
        int e;
        e = sb.pop_front();
        chk(eval_done_o == 1'b1, "R1 eval_done at evaluation", int'(eval_done_o), 1);
        chk(int'(drv_code_o) == e, "R3 code after evaluation", int'(drv_code_o), e);
      end else begin
        chk(eval_done_o == 1'b0, "R9 eval_done outside evaluation", int'(eval_done_o), 0);
        chk(int'(drv_code_o) == exp_code, "R4 code stable between evaluations",
            int'(drv_code_o), exp_code);
      end
      if (odt_en_i)
        chk(int'(term_code_o) == term_of(exp_code), "R7 derived term code",
            int'(term_code_o), term_of(exp_code));
      else
        chk(term_code_o == '0, "R8 gated term code", int'(term_code_o), 0);
      // comparator drive
      case (mode)
        0: cmp_i = (exp_code > target) ? 2'b01 : (exp_code < target) ? 2'b10 : 2'b00;
        1: cmp_i = 2'b10;
        2: cmp_i = 2'b01;
        3: cmp_i = (bcnt == 0) ? 2'b00 : 2'b10;
        default: cmp_i = 2'b11;
      endcase
      // prediction for the coming edge
      if (bcnt == 0) begin
        if (cmp_i == 2'b10 && exp_code != 63) exp_code++;
        else if (cmp_i == 2'b01 && exp_code != 0) exp_code--;
        sb.push_back(exp_code);
        bcnt = IV - 1;
      end else begin
        bcnt--;
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R2: reset state
    chk(int'(drv_code_o) == 32, "R2 reset code", int'(drv_code_o), 32);
    chk(eval_done_o == 1'b0, "R2 reset done", int'(eval_done_o), 0);
    chk(term_code_o == '0, "R2 reset term gated", int'(term_code_o), 0);
    rst_ni = 1'b1;
    bcnt   = IV - 2;
    armed  = 1;
    @(posedge clk_i); #1;
    odt_en_i = 1'b1;
    #1;
    chk(int'(term_code_o) == 11, "R8 enable restores term", int'(term_code_o), 11);
    mode = 0; target = 40;
    run_iv(12);
    chk(int'(drv_code_o) == 40, "R3 converge up", int'(drv_code_o), 40);
    odt_en_i = 1'b0; target = 25;
    run_iv(20);
    chk(int'(drv_code_o) == 25, "R8 calibration continues while disabled", int'(drv_code_o), 25);
    chk(term_code_o == '0, "R8 term zero while disabled", int'(term_code_o), 0);
    odt_en_i = 1'b1;
    #1;
    chk(int'(term_code_o) == 8, "R7 term after re-enable", int'(term_code_o), 8);
    mode = 3;
    run_iv(5);
    chk(int'(drv_code_o) == 25, "R4 off-strobe requests ignored", int'(drv_code_o), 25);
    mode = 4;
    run_iv(3);
    chk(int'(drv_code_o) == 25, "R3 both bits hold", int'(drv_code_o), 25);
    mode = 1;
    run_iv(45);
    chk(int'(drv_code_o) == 63, "R5 saturate at all-ones", int'(drv_code_o), 63);
    chk(int'(term_code_o) == 21, "R7 term at full scale", int'(term_code_o), 21);
    mode = 2;
    run_iv(70);
    chk(int'(drv_code_o) == 0, "R6 saturate at zero", int'(drv_code_o), 0);
    chk(int'(term_code_o) == 0, "R7 term at zero", int'(term_code_o), 0);
    mode = 0; target = 1;
    run_iv(3);
    chk(int'(drv_code_o) == 1, "R3 settle near bottom", int'(drv_code_o), 1);
    @(negedge clk_i);
    finish_run();
  end
endmodule